// File: doc/BRIEF.md
# Pipelined Unsigned Array Multiplier

This block multiplies two unsigned operands of `W` bits each and returns their full `2W`-bit product. It is built as an array of `W` rows. Every row is a chain of conditional-add full-adder cells. A row adds the multiplicand into the running partial sum only when its own multiplier bit is 1. When that bit is 0, the row passes the sum through with its carry. The first row starts from a running sum of zero. Each row retires one low product bit and hands the upper part of the sum, shifted down by one, to the next row.

A register bank sits after every row and one more sits at the output. Operand bits that later rows still need travel in delay registers beside the partial sum, so each row always works on a single transaction. Each later row keeps one fewer multiplier bit. A valid flag moves with every stage.

Both edges of the block are valid/ready streams. When the consumer keeps `out_ready` high, the block accepts a new operand pair on every clock and never stalls. When the output holds a product that is not taken (`out_valid` high, `out_ready` low), the whole pipeline freezes and `in_ready` drops. Nothing moves until the consumer takes the product. A pair is accepted on a rising edge only when `in_valid` and `in_ready` are both high.

Top module: `umul_array`

## Requirements
- R1: For every accepted pair, `out_product` equals `in_a * in_b` as an unsigned `2W`-bit value (16 bits by default).
- R2: With `out_ready` held high, the product of a pair appears on the outputs `W` clock edges after the edge that accepted it. The pair passes through `W+1` register banks.
- R3: While `out_ready` is high, `in_ready` is high and a new pair can be accepted on every consecutive edge without waiting.
- R4: A row whose multiplier bit is 0 adds nothing. So a zero operand on either side gives a product of 0, and a multiplier with a single 1 bit at position k gives the multiplicand shifted left by k.
- R5: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.
- R6: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0. On the next edge, `out_valid` stays 1 and `out_product` keeps its value.
- R7: A product is delivered only for an accepted pair. Cycles in which `in_valid` or `in_ready` is low, or `rst_n` is low, create no output beat. The number of pairs in flight never exceeds `W+1`.
- R8: Products leave in the same order as their pairs were accepted.
- R9: All-ones operands give `(2^W-1)^2`, which is `16'hFE01` at the default width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair on `in_a`/`in_b` is valid |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| in_a | input | W | Multiplicand |
| in_b | input | W | Multiplier |
| out_valid | output | 1 | `out_product` holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_product | output | 2W | Unsigned product |

## Verification
The bench builds the block at its default width of 8 bits. At that width the hand-computed corner products can be listed directly, including all-ones, single-bit and zero operands. It also keeps the 9-register pipeline short enough to fill completely during a stall test. A width this small also lets the random stream of operand pairs reach the carry-out of the top row often. The freeze test holds `out_ready` low until the output register is loaded, then checks that the result and the queued pairs stay put.

// File: rtl/umul_pkg.sv
package umul_pkg;

  localparam int unsigned UMUL_W_DEF = 8;

  // edges from the accepting edge to the output register
  function automatic int unsigned umul_lat(input int unsigned w);
    return w;
  endfunction

endpackage

// File: rtl/umul_gfa_cell.sv
// Conditional-add full adder: the multiplicand bit joins the sum only when
// the multiplier bit is set.
module umul_gfa_cell (
  input  logic x,
  input  logic y,
  input  logic z,
  input  logic ci,
  output logic s,
  output logic co
);

  logic xg;

  assign xg = x & z;
  assign s  = xg ^ y ^ ci;
  assign co = (xg & y) | (xg & ci) | (y & ci);

endmodule

// File: rtl/umul_row.sv
// One array row: ripple chain of gated cells plus the stage register for
// the partial sum, the retired low product bits and the valid flag.
module umul_row #(
  parameter int unsigned W   = 8,
  parameter int unsigned ROW = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         v_i,
  input  logic [W-1:0] a_i,
  input  logic         z_i,
  input  logic [W-1:0] sum_i,
  input  logic [W-1:0] lo_i,
  output logic         v_o,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] lo_o
);

  logic [W:0]   carry;
  logic [W-1:0] s;
  logic [W-1:0] sum_nx;
  logic [W-1:0] lo_nx;

  assign carry[0] = 1'b0;

  for (genvar k = 0; k < W; k++) begin : g_cell
    umul_gfa_cell u_cell (
      .x  (a_i[k]),
      .y  (sum_i[k]),
      .z  (z_i),
      .ci (carry[k]),
      .s  (s[k]),
      .co (carry[k+1])
    );
  end

  // the bit at position ROW of lo_i is still zero on entry to this row
  always_comb begin
    sum_nx = {carry[W], s[W-1:1]};
    lo_nx  = lo_i | (W'(s[0]) << ROW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o   <= 1'b0;
      sum_o <= '0;
      lo_o  <= '0;
    end else if (adv) begin
      v_o   <= v_i;
      sum_o <= sum_nx;
      lo_o  <= lo_nx;
    end
  end

endmodule

// File: rtl/umul_array.sv
module umul_array #(
  parameter int unsigned W = umul_pkg::UMUL_W_DEF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*W-1:0] out_product
);

  localparam int unsigned PW = 2 * W;

  logic          adv;
  logic          accept;
  logic          ov_q;
  logic [PW-1:0] prod_q;

  // whole pipeline moves together; it freezes only on an untaken result
  assign adv    = !ov_q || out_ready;
  assign accept = in_valid && adv;

  for (genvar k = 0; k < W; k++) begin : g_st
    logic         v_use;
    logic [W-1:0] a_use;
    logic [W-1-k:0] b_use;
    logic [W-1:0] sum_use;
    logic [W-1:0] lo_use;
    logic         v_q;
    logic [W-1:0] sum_q;
    logic [W-1:0] lo_q;

    if (k == 0) begin : g_head
      assign v_use   = accept;
      assign a_use   = in_a;
      assign b_use   = in_b;
      assign sum_use = '0;
      assign lo_use  = '0;
    end else begin : g_link
      assign v_use   = g_st[k-1].v_q;
      assign a_use   = g_st[k-1].g_dly.a_q;
      assign b_use   = g_st[k-1].g_dly.b_q;
      assign sum_use = g_st[k-1].sum_q;
      assign lo_use  = g_st[k-1].lo_q;
    end

    umul_row #(.W(W), .ROW(k)) u_row (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .v_i   (v_use),
      .a_i   (a_use),
      .z_i   (b_use[0]),
      .sum_i (sum_use),
      .lo_i  (lo_use),
      .v_o   (v_q),
      .sum_o (sum_q),
      .lo_o  (lo_q)
    );

    // operand delay: later rows need the whole multiplicand but only the
    // multiplier bits not yet consumed
    if (k < W - 1) begin : g_dly
      logic [W-1:0]   a_q;
      logic [W-2-k:0] b_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          a_q <= '0;
          b_q <= '0;
        end else if (adv) begin
          a_q <= a_use;
          b_q <= b_use[W-1-k:1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q   <= 1'b0;
      prod_q <= '0;
    end else if (adv) begin
      ov_q   <= g_st[W-1].v_q;
      prod_q <= {g_st[W-1].sum_q, g_st[W-1].lo_q};
    end
  end

  assign in_ready    = adv;
  assign out_valid   = ov_q;
  assign out_product = prod_q;

endmodule

// File: rtl/umul_array_chk.sv
module umul_array_chk #(
  parameter int unsigned W = umul_pkg::UMUL_W_DEF
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [W-1:0]   in_a,
  input logic [W-1:0]   in_b,
  input logic           out_valid,
  input logic           out_ready,
  input logic [2*W-1:0] out_product
);

  localparam int unsigned DEPTH = umul_pkg::umul_lat(W) + 1;
  localparam int unsigned CW    = $clog2(DEPTH + 2) + 1;
  localparam logic [2*W-1:0] PMAX = {{(W-1){1'b1}}, 1'b0, {(W-1){1'b0}}, 1'b1};

  logic [CW-1:0] inflight;
  logic          acc;
  logic          dlv;

  assign acc = in_valid && in_ready;
  assign dlv = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else        inflight <= inflight + CW'(acc) - CW'(dlv);
  end

  p_reset_idle_r5: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && in_ready));

  p_ready_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  p_stall_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_product)));

  p_no_phantom_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (inflight != '0));

  p_depth_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CW'(DEPTH));

  p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_product <= PMAX));

  // unused operand pins are observed for X during accepted beats
  p_known_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> (!$isunknown(in_a) && !$isunknown(in_b)));

endmodule

bind umul_array umul_array_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_a        (in_a),
  .in_b        (in_b),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_product (out_product)
);

// File: tb/umul_array_tb.sv
`timescale 1ns/1ps
module umul_array_tb;

  localparam int unsigned W = 8;

  // {a, b, expected product}
  localparam logic [31:0] VEC [13] = '{
    32'h00_00_0000,  // R4 zero x zero
    32'hFF_FF_FE01,  // R9 all ones
    32'hFF_00_0000,  // R4 zero multiplier
    32'h00_FF_0000,  // R4 zero multiplicand
    32'h01_FF_00FF,
    32'hFF_01_00FF,
    32'h80_80_4000,
    32'h0F_F0_0E10,
    32'hAA_55_3872,
    32'h12_34_03A8,
    32'h7F_81_3FFF,
    32'hC8_64_4E20,
    32'h5B_04_016C   // R4 single multiplier bit -> shift by 2
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [W-1:0]   in_a = '0;
  logic [W-1:0]   in_b = '0;
  logic           out_valid;
  logic           out_ready = 1'b1;
  logic [2*W-1:0] out_product;

  int n_chk  = 0;
  int n_fail = 0;
  int n_sent = 0;
  int n_out  = 0;
  bit done   = 1'b0;
  logic [15:0] exp_q [$];

  always #2.5 clk = ~clk;

  umul_array #(.W(W)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_a        (in_a),
    .in_b        (in_b),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_product (out_product)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send(input logic [7:0] a, input logic [7:0] b,
                      input logic [15:0] e, output int waits);
    waits    = 0;
    in_valid = 1'b1;
    in_a     = a;
    in_b     = b;
    forever begin
      if (in_ready) begin
        exp_q.push_back(e);
        n_sent++;
        @(negedge clk);
        break;
      end
      @(negedge clk);
      waits++;
    end
  endtask

  // R1, R8: every delivered beat matches the oldest outstanding pair
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      n_out++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 beat without pair", 32'(out_product), 32'h0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(out_product == e, "R1/R8 product", 32'(out_product), 32'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 32'(exp_q.size()), 32'h0);
    finish_run();
  end

  initial begin
    int w;
    logic [15:0] held;

    // R5 and R7: reset state, and in_valid during reset is ignored
    in_valid = 1'b1;
    in_a = 8'h33;
    in_b = 8'h44;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R5 out_valid in reset", 32'(out_valid), 32'h0);
    chk(in_ready == 1'b1, "R5 in_ready in reset", 32'(in_ready), 32'h1);
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (W + 3) @(negedge clk);
    chk(out_valid == 1'b0, "R7 no beat from reset input", 32'(out_valid), 32'h0);

    // R2 and R9: single pair latency and all-ones product
    send(8'hFF, 8'hFF, 16'hFE01, w);
    in_valid = 1'b0;
    repeat (W - 1) @(negedge clk);
    chk(out_valid == 1'b0, "R2 early result", 32'(out_valid), 32'h0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R2 result on time", 32'(out_valid), 32'h1);
    chk(out_product == 16'hFE01, "R9 all ones", 32'(out_product), 32'hFE01);
    repeat (2) @(negedge clk);

    // R3, R4: table streamed back to back, each accepted without waiting
    for (int i = 0; i < 13; i++) begin
      send(VEC[i][31:24], VEC[i][23:16], VEC[i][15:0], w);
      chk(w == 0, "R3 back-to-back accept", 32'(w), 32'h0);
    end
    in_valid = 1'b0;
    repeat (W + 4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 table drained", 32'(exp_q.size()), 32'h0);

    // R6: freeze under back-pressure
    out_ready = 1'b0;
    send(8'h21, 8'h03, 16'h0063, w);
    send(8'h10, 8'h10, 16'h0100, w);
    send(8'hFE, 8'h02, 16'h01FC, w);
    in_valid = 1'b0;
    repeat (12) @(negedge clk);
    chk(out_valid == 1'b1, "R6 result waiting", 32'(out_valid), 32'h1);
    chk(in_ready == 1'b0, "R6 in_ready low", 32'(in_ready), 32'h0);
    held = out_product;
    chk(held == 16'h0063, "R8 oldest first", 32'(held), 32'h63);
    repeat (3) @(negedge clk);
    chk(out_product == held && out_valid, "R6 product held",
        32'(out_product), 32'(held));
    chk(exp_q.size() == 3, "R6 nothing consumed", 32'(exp_q.size()), 32'h3);
    out_ready = 1'b1;
    repeat (W + 4) @(negedge clk);

    // R1, R8: random stream with occasional idle cycles
    for (int i = 0; i < 150; i++) begin
      logic [7:0] a;
      logic [7:0] b;
      a = 8'($urandom_range(0, 255));
      b = 8'($urandom_range(0, 255));
      send(a, b, 16'(a) * 16'(b), w);
      if ($urandom_range(0, 3) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);

    chk(n_out == n_sent, "R7 beats equal accepts", 32'(n_out), 32'(n_sent));
    chk(out_valid == 1'b0, "R7 idle after drain", 32'(out_valid), 32'h0);
    finish_run();
  end

endmodule